// File: doc/BRIEF.md
# Processor status and interrupt gate

This block holds the processor's 8-bit status word: a 3-bit interrupt level, an interrupt-enable bit and four condition flags (carry, overflow, zero, negative). The execution unit updates the flags, and software may write only the enable bit. Around the register sits the acceptance logic for maskable interrupts. Among the pending requests it picks the most urgent one. It accepts that request only when interrupts are enabled and the request's level is strictly above the level held in the register.

On acceptance the block raises a one-cycle pulse and, in the same cycle, presents the status value to be pushed to the stack. On the following edge it clears the enable bit and loads the level field with the accepted level. A return strobe reloads the whole word from a value popped off the stack. A debug-entry strobe leaves the word unsaved and the enable bit untouched, and it holds off maskable acceptance for that cycle. Stack memory and vector fetch sit outside the block.

Top module: `psr_gate`

## Requirements
- R1: After reset the status word reads 0x00.
- R2: The flags occupy bits 3 (C), 2 (V), 1 (Z) and 0 (N). Each flag changes only when its own bit of `flag_we` is set (flag_we[3]=C … flag_we[0]=N), and it then takes the matching bit of `flag_val`.
- R3: A software write through `ie_wr` changes only bit 4 (IE). The level field in bits 7..5 changes only on acceptance, on return, or on reset.
- R4: `take` is high only when IE is 1 and the chosen request's level is strictly greater than the level field.
- R5: In a cycle with `take` high, `push_data` equals the current word with that cycle's flag updates applied. On the next edge IE becomes 0, the level field becomes the accepted level and the flags keep their updated values. When `take` is low, `push_data` is 0x00.
- R6: With several requests pending, the highest level wins. On a tie the lowest request index wins, and that index appears on `take_idx`.
- R7: While `dbg_entry` is high, `take` stays low and IE and the level field are not changed by interrupt entry. Flag and IE writes in that cycle still apply.
- R8: A `reti` strobe loads the whole word from `reti_data` on the next edge. It overrides any flag or IE write in the same cycle and blocks acceptance in that cycle.
- R9: A request held high after acceptance does not produce a second `take` in the next cycle.
- R10: After acceptance, a request at the same or a lower level stays masked even with IE set again, until the level field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_we | input | 4 | Per-flag update enables (C,V,Z,N) |
| flag_val | input | 4 | New flag values |
| ie_wr | input | 1 | Software write strobe for IE |
| ie_wdata | input | 1 | Value written to IE |
| irq_req | input | N_REQ | Pending maskable requests |
| irq_lvl | input | N_REQ*LVL_W | Request levels, request i in bits [LVL_W*i +: LVL_W] |
| dbg_entry | input | 1 | Debug interrupt entry strobe |
| reti | input | 1 | Return-from-interrupt strobe |
| reti_data | input | 8 | Status value popped from the stack |
| status | output | 8 | Current status word |
| take | output | 1 | Maskable interrupt accepted this cycle |
| take_idx | output | IDX_W | Index of the accepted request |
| take_lvl | output | LVL_W | Level of the accepted request |
| push_data | output | 8 | Status value to push to the stack |

## Verification
The hardest state to reach is a masked request that stays masked with IE set again: it takes an acceptance, then a software IE write, then the same request held at the now-current level. The vector table walks through exactly that order and afterwards raises a higher request to show that the mask lifts. A second hard case is a collision between an acceptance and a flag update, or between a return and a pending request. The table places these strobes in the same cycle, so the merged pushed value and the priority of return are both observed.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int FLAG_W = 4;

  // Apply per-bit flag updates on top of the current flags.
  function automatic logic [FLAG_W-1:0] flags_apply(
    input logic [FLAG_W-1:0] cur,
    input logic [FLAG_W-1:0] we,
    input logic [FLAG_W-1:0] val
  );
    return (cur & ~we) | (val & we);
  endfunction

  // A request beats the current level only when strictly above it.
  function automatic logic lvl_beats(
    input logic [7:0] req_lvl,
    input logic [7:0] cur_lvl
  );
    return req_lvl > cur_lvl;
  endfunction

endpackage

// File: rtl/psr_req_pick.sv
module psr_req_pick #(
  parameter int N_REQ = 4,
  parameter int LVL_W = 3,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0]       req,
  input  logic [N_REQ*LVL_W-1:0] lvl_flat,
  output logic                   hit,
  output logic [LVL_W-1:0]       win_lvl,
  output logic [IDX_W-1:0]       win_idx
);

  logic [LVL_W-1:0] lvl_a [N_REQ];

  for (genvar g = 0; g < N_REQ; g++) begin : g_unpack
    assign lvl_a[g] = lvl_flat[g*LVL_W +: LVL_W];
  end

  // Linear scan: strict compare keeps the lowest index on ties.
  always_comb begin
    hit     = 1'b0;
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (req[i] && (!hit || (lvl_a[i] > win_lvl))) begin
        hit     = 1'b1;
        win_lvl = lvl_a[i];
        win_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/psr_next.sv
module psr_next #(
  parameter int LVL_W = 3,
  localparam int ST_W = LVL_W + 1 + psr_pkg::FLAG_W
) (
  input  logic [ST_W-1:0]            cur,
  input  logic [psr_pkg::FLAG_W-1:0] fwe,
  input  logic [psr_pkg::FLAG_W-1:0] fval,
  input  logic                       ie_wr,
  input  logic                       ie_wd,
  input  logic                       accept,
  input  logic [LVL_W-1:0]           acc_lvl,
  input  logic                       reti,
  input  logic [ST_W-1:0]            reti_data,
  output logic [ST_W-1:0]            merged,
  output logic [ST_W-1:0]            nxt
);
  import psr_pkg::*;

  localparam int IE_B = FLAG_W;

  logic [FLAG_W-1:0] flags_new;
  logic              ie_new;

  assign flags_new = flags_apply(cur[FLAG_W-1:0], fwe, fval);
  assign merged    = {cur[ST_W-1:FLAG_W], flags_new};
  assign ie_new    = ie_wr ? ie_wd : cur[IE_B];

  always_comb begin
    if (reti)        nxt = reti_data;
    else if (accept) nxt = {acc_lvl, 1'b0, flags_new};
    else             nxt = {cur[ST_W-1:IE_B+1], ie_new, flags_new};
  end

endmodule

// File: rtl/psr_gate.sv
module psr_gate #(
  parameter int N_REQ = 4,
  parameter int LVL_W = 3,
  localparam int ST_W  = LVL_W + 1 + psr_pkg::FLAG_W,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [psr_pkg::FLAG_W-1:0] flag_we,
  input  logic [psr_pkg::FLAG_W-1:0] flag_val,
  input  logic                       ie_wr,
  input  logic                       ie_wdata,
  input  logic [N_REQ-1:0]           irq_req,
  input  logic [N_REQ*LVL_W-1:0]     irq_lvl,
  input  logic                       dbg_entry,
  input  logic                       reti,
  input  logic [ST_W-1:0]            reti_data,
  output logic [ST_W-1:0]            status,
  output logic                       take,
  output logic [IDX_W-1:0]           take_idx,
  output logic [LVL_W-1:0]           take_lvl,
  output logic [ST_W-1:0]            push_data
);
  import psr_pkg::*;

  localparam int IE_B = FLAG_W;

  logic [ST_W-1:0]  psr_q, psr_d, merged;
  logic             win_hit, gate_open, accept;
  logic [LVL_W-1:0] win_lvl, cur_il;
  logic [IDX_W-1:0] win_idx;

  assign cur_il = psr_q[ST_W-1:IE_B+1];

  psr_req_pick #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_pick (
    .req(irq_req), .lvl_flat(irq_lvl),
    .hit(win_hit), .win_lvl(win_lvl), .win_idx(win_idx)
  );

  assign gate_open = psr_q[IE_B] && !dbg_entry && !reti;
  assign accept    = gate_open && win_hit && lvl_beats(8'(win_lvl), 8'(cur_il));

  psr_next #(.LVL_W(LVL_W)) u_next (
    .cur(psr_q), .fwe(flag_we), .fval(flag_val),
    .ie_wr(ie_wr), .ie_wd(ie_wdata),
    .accept(accept), .acc_lvl(win_lvl),
    .reti(reti), .reti_data(reti_data),
    .merged(merged), .nxt(psr_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psr_q <= '0;
    else        psr_q <= psr_d;
  end

  assign status    = psr_q;
  assign take      = accept;
  assign take_idx  = accept ? win_idx : '0;
  assign take_lvl  = accept ? win_lvl : '0;
  assign push_data = accept ? merged : '0;

endmodule

// File: rtl/psr_gate_chk.sv
module psr_gate_chk #(
  parameter int N_REQ = 4,
  parameter int LVL_W = 3,
  localparam int ST_W  = LVL_W + 5,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_entry,
  input logic             reti,
  input logic [ST_W-1:0]  reti_data,
  input logic [ST_W-1:0]  status,
  input logic             take,
  input logic [LVL_W-1:0] take_lvl,
  input logic [ST_W-1:0]  push_data
);
  localparam int IE_B = 4;

  AST_TAKE_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (status[IE_B] && (take_lvl > status[ST_W-1:IE_B+1]))); // R4
  AST_TAKE_LOADS_IL: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status[ST_W-1:IE_B+1] == $past(take_lvl)) && !status[IE_B]); // R5
  AST_TAKE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (status[IE_B-1:0] == $past(push_data[IE_B-1:0]))); // R5
  AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (push_data == '0)); // R5
  AST_DBG_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_entry |-> !take); // R7
  AST_RETI_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    reti |=> (status == $past(reti_data))); // R8
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !take); // R9
  AST_IL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !reti) |=> $stable(status[ST_W-1:IE_B+1])); // R3
endmodule

bind psr_gate psr_gate_chk #(.N_REQ(N_REQ), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_entry(dbg_entry), .reti(reti),
  .reti_data(reti_data), .status(status), .take(take),
  .take_lvl(take_lvl), .push_data(push_data)
);

// File: tb/psr_gate_tb.sv
`timescale 1ns/1ps
module psr_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  flag_we = '0, flag_val = '0;
  logic        ie_wr = 1'b0, ie_wdata = 1'b0;
  logic [3:0]  irq_req = '0;
  logic [11:0] irq_lvl = '0;
  logic        dbg_entry = 1'b0, reti = 1'b0;
  logic [7:0]  reti_data = '0;
  logic [7:0]  status, push_data;
  logic        take;
  logic [1:0]  take_idx;
  logic [2:0]  take_lvl;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  psr_gate u_dut (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .flag_val(flag_val),
    .ie_wr(ie_wr), .ie_wdata(ie_wdata), .irq_req(irq_req), .irq_lvl(irq_lvl),
    .dbg_entry(dbg_entry), .reti(reti), .reti_data(reti_data),
    .status(status), .take(take), .take_idx(take_idx), .take_lvl(take_lvl),
    .push_data(push_data)
  );

  typedef struct packed {
    logic [3:0]  fwe;   logic [3:0] fval;
    logic        iew;   logic       ied;
    logic [3:0]  req;   logic [11:0] lvl;
    logic        dbg;   logic       rt;   logic [7:0] rdat;
    logic        e_take; logic [1:0] e_idx;
    logic [7:0]  e_push; logic [7:0] e_stat;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{4'h0,4'h0,1,1,4'h0,12'h000,0,0,8'h00, 0,2'd0,8'h00,8'h10, 8'd3},  // R3 IE on
    '{4'hF,4'hA,0,0,4'h0,12'h000,0,0,8'h00, 0,2'd0,8'h00,8'h1A, 8'd2},  // R2 all flags
    '{4'h8,4'h0,0,0,4'h0,12'h000,0,0,8'h00, 0,2'd0,8'h00,8'h12, 8'd2},  // R2 C only
    '{4'h0,4'h0,0,0,4'h2,12'h018,0,0,8'h00, 1,2'd1,8'h12,8'h62, 8'd5},  // R4 R5 accept lvl3
    '{4'h0,4'h0,0,0,4'h2,12'h018,0,0,8'h00, 0,2'd0,8'h00,8'h62, 8'd9},  // R9 held
    '{4'h0,4'h0,1,1,4'h2,12'h018,0,0,8'h00, 0,2'd0,8'h00,8'h72, 8'd3},  // R3 IE on again
    '{4'h0,4'h0,0,0,4'h2,12'h018,0,0,8'h00, 0,2'd0,8'h00,8'h72, 8'd10}, // R10 same level masked
    '{4'h1,4'h1,0,0,4'hD,12'hB42,0,0,8'h00, 1,2'd2,8'h73,8'hA3, 8'd6},  // R6 R5 max, tie, merge
    '{4'hF,4'h0,1,0,4'h0,12'h000,0,1,8'h72, 0,2'd0,8'h00,8'h72, 8'd8},  // R8 reti wins
    '{4'h1,4'h1,0,0,4'h8,12'hE00,1,0,8'h00, 0,2'd0,8'h00,8'h73, 8'd7},  // R7 debug
    '{4'h0,4'h0,0,0,4'h8,12'hE00,0,1,8'hF0, 0,2'd0,8'h00,8'hF0, 8'd8},  // R8 blocks take
    '{4'h0,4'h0,0,0,4'h8,12'hE00,0,0,8'h00, 0,2'd0,8'h00,8'hF0, 8'd10}, // R10 7 vs 7
    '{4'h0,4'h0,1,0,4'h0,12'h000,0,0,8'h00, 0,2'd0,8'h00,8'hE0, 8'd3},  // R3 IE off
    '{4'h0,4'h0,0,0,4'h0,12'h000,0,1,8'h1F, 0,2'd0,8'h00,8'h1F, 8'd8},  // R8 load
    '{4'h0,4'h0,0,0,4'h3,12'h009,0,0,8'h00, 1,2'd0,8'h1F,8'h2F, 8'd6}   // R6 tie low index
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    flag_we = '0; flag_val = '0; ie_wr = 0; ie_wdata = 0;
    irq_req = '0; irq_lvl = '0; dbg_entry = 0; reti = 0; reti_data = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset value", status, 8'h00);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      flag_we = VEC[k].fwe; flag_val = VEC[k].fval;
      ie_wr = VEC[k].iew; ie_wdata = VEC[k].ied;
      irq_req = VEC[k].req; irq_lvl = VEC[k].lvl;
      dbg_entry = VEC[k].dbg; reti = VEC[k].rt; reti_data = VEC[k].rdat;
      #1;
      chk($sformatf("R%0d row %0d take", VEC[k].rq, k), {7'd0, take}, {7'd0, VEC[k].e_take});
      chk($sformatf("R%0d row %0d idx", VEC[k].rq, k), {6'd0, take_idx}, {6'd0, VEC[k].e_idx});
      chk($sformatf("R%0d row %0d push", VEC[k].rq, k), push_data, VEC[k].e_push);
      @(negedge clk);
      chk($sformatf("R%0d row %0d status", VEC[k].rq, k), status, VEC[k].e_stat);
      idle();
    end
    // Directed: IE write in the accept cycle is overridden (R5), then reset (R1).
    @(negedge clk);
    reti = 1; reti_data = 8'h15;
    @(negedge clk);
    reti = 0; ie_wr = 1; ie_wdata = 1; irq_req = 4'h4; irq_lvl = 12'h180;
    #1 chk("R5 accept with IE write take", {7'd0, take}, 8'h01);
    @(negedge clk);
    chk("R5 IE cleared after accept", status, 8'hC5);
    idle();
    rst_n = 1'b0;
    #1 chk("R1 reset mid-run", status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    irq_req = 4'h1; irq_lvl = 12'h007;
    #1 chk("R4 IE clear blocks request", {7'd0, take}, 8'h00);
    idle();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule